// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block sends words out on a single data line, one bit per cycle of a shift clock that an external master drives. The master owns the clock. The block brings that clock into its own system clock domain through a synchroniser, detects its edges, and updates the data line on each leading edge. The master samples the line on the trailing edge. Because all the shifting is paced by the external clock, the interrupt request can serve as a wake event.

Software reaches the block through a small register bus. A two-stage buffer (a holding register in front of a shift register) lets one word wait while another is sent. A flag reports when the holding register has been handed on to the shift register. Words are 8 bits long, or 9 bits when the ninth-bit mode is on.

Top module: `sync_slave_tx`

## Requirements
- R1: Transmission is enabled only when all of these hold: port_en (port control bit 0) is 1, tx_en (tx control bit 0) is 1, sync_mode (tx control bit 1) is 1, master_sel (tx control bit 2) is 0, rx_cont (port control bit 1) is 0 and rx_single (port control bit 2) is 0. While any one of them fails, both buffers are held empty, writes to the data address (0) are ignored, and txd does not change.
- R2: A word written to address 0 while the shift register is empty is loaded into the shift register on the next cycle. At that point hold_empty (status bit 0) sets and shift_empty (status bit 1) clears.
- R3: A word written while the shift register is busy waits in the holding register. hold_empty reads 0 from the write until the busy word has fully shifted out.
- R4: Once the last bit's trailing edge has been seen, the waiting word moves into the shift register and hold_empty sets. If no word is waiting, shift_empty sets instead.
- R5: Bits go out least significant bit first. txd changes only on a leading edge of the synchronised shift clock, so it is stable across the trailing edge.
- R6: With nine_bit (tx control bit 3) set, each word is 9 bits long. The ninth bit is the value of bit9 (tx control bit 4) at the time the word was written, and it is sent last.
- R7: irq is 1 exactly when hold_empty is 1 and irq_en (port control bit 3) is 1.
- R8: After reset, shift_empty is 1. Every control bit, hold_empty, irq and txd are 0.
- R9: clk_pol (tx control bit 5) is the idle level of the shift clock. The leading edge is the departure from that level and the trailing edge is the return to it.
- R10: Clearing tx_en or port_en in the middle of a word aborts it. Both buffers empty, shift_empty sets, hold_empty keeps its value, and later clock pulses send nothing.
- R11: Reads return the tx control byte at address 1, the port control byte at address 2 and the status byte at address 3 (bit 2 = irq). Address 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the shift clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_sclk | input | 1 | Shift clock from the external master |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational from bus_addr |
| txd | output | 1 | Serial data out |
| irq | output | 1 | Transmit interrupt request |

## Verification
Some rules are checked by assertions on every cycle:
- when the path is gated, both buffers empty by the next cycle;
- a load always sets hold_empty and marks the shift register busy;
- a write that arrives while the shift register is busy keeps hold_empty low;
- completing a word frees the shift register;
- txd only moves on a leading edge;
- the bit counter stays within the word length;
- irq is never raised without hold_empty.

Other behaviour can only be shown by the bench's scenarios. This covers the actual bit order on the line, how the ninth bit is captured, both clock polarities, the order of two queued words, and what happens after an abort.

// File: rtl/sst_pkg.sv
package sst_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA    = 2'd0,
    A_TXCTL   = 2'd1,
    A_PORTCTL = 2'd2,
    A_STATUS  = 2'd3
  } sst_addr_e;

  // packed MSB first: clk_pol is bit 5, tx_en is bit 0
  typedef struct packed {
    logic clk_pol;
    logic bit9;
    logic nine_bit;
    logic master_sel;
    logic sync_mode;
    logic tx_en;
  } tx_ctl_t;

  // irq_en is bit 3, port_en is bit 0
  typedef struct packed {
    logic irq_en;
    logic rx_single;
    logic rx_cont;
    logic port_en;
  } port_ctl_t;

  function automatic logic path_active(tx_ctl_t t, port_ctl_t p);
    return p.port_en && t.tx_en && t.sync_mode && !t.master_sel &&
           !p.rx_cont && !p.rx_single;
  endfunction

  function automatic int unsigned word_bits(logic nine, int unsigned dw);
    return nine ? dw + 1 : dw;
  endfunction

endpackage

// File: rtl/sst_edge.sv
module sst_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic pol,
  output logic lead,
  output logic trail
);

  logic [STAGES-1:0] chain;
  logic              prev;
  logic              lvl;
  logic              rise;
  logic              fall;

  assign lvl = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], sclk_in};
      prev  <= lvl;
    end
  end

  assign rise  = lvl && !prev;
  assign fall  = !lvl && prev;
  // leading edge leaves the idle level given by pol
  assign lead  = pol ? fall : rise;
  assign trail = pol ? rise : fall;

endmodule

// File: rtl/sst_regs.sv
module sst_regs
  import sst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              st_hold_empty,
  input  logic              st_shift_empty,
  input  logic              st_irq,
  output tx_ctl_t           tx_ctl,
  output port_ctl_t         port_ctl,
  output logic              data_wr,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int TXC_W = $bits(tx_ctl_t);
  localparam int PC_W  = $bits(port_ctl_t);

  sst_addr_e addr;
  assign addr    = sst_addr_e'(bus_addr);
  assign data_wr = bus_wr && (addr == A_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ctl   <= '0;
      port_ctl <= '0;
    end else if (bus_wr) begin
      case (addr)
        A_TXCTL:   tx_ctl   <= tx_ctl_t'(bus_wdata[TXC_W-1:0]);
        A_PORTCTL: port_ctl <= port_ctl_t'(bus_wdata[PC_W-1:0]);
        default:   ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (addr)
      A_TXCTL:   bus_rdata[TXC_W-1:0] = tx_ctl;
      A_PORTCTL: bus_rdata[PC_W-1:0]  = port_ctl;
      A_STATUS:  bus_rdata[2:0]       = {st_irq, st_shift_empty, st_hold_empty};
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              nine_bit,
  input  logic              lead,
  input  logic              trail,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              hold_valid,
  output logic              load_evt,
  output logic              done_evt,
  output logic              wr_acc,
  output logic              shift_evt,
  output logic [CNT_W-1:0]  bit_cnt
);

  localparam int SH_W = DATA_W + 1;

  logic [SH_W-1:0]  hold_q;
  logic [SH_W-1:0]  sh_q;
  logic             nine_q;
  logic             busy;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt    = CNT_W'(word_bits(nine_q, DATA_W));
  assign shift_empty = !busy;
  assign wr_acc      = active && data_wr;
  assign load_evt    = active && hold_valid && !busy;
  assign shift_evt   = active && busy && lead && (bit_cnt < last_cnt);
  assign done_evt    = active && busy && trail && (bit_cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= '0;
      sh_q       <= '0;
      nine_q     <= 1'b0;
      busy       <= 1'b0;
      bit_cnt    <= '0;
      hold_valid <= 1'b0;
      hold_empty <= 1'b0;
      txd        <= 1'b0;
    end else if (!active) begin
      hold_valid <= 1'b0;
      busy       <= 1'b0;
      bit_cnt    <= '0;
    end else begin
      if (done_evt) busy <= 1'b0;
      if (shift_evt) begin
        txd     <= sh_q[0];
        sh_q    <= sh_q >> 1;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (load_evt) begin
        sh_q       <= hold_q;
        nine_q     <= nine_bit;
        bit_cnt    <= '0;
        busy       <= 1'b1;
        hold_valid <= 1'b0;
        hold_empty <= 1'b1;
      end
      // a write in the same cycle as a load queues the new word
      if (wr_acc) begin
        hold_q     <= {wr_bit9, wr_data};
        hold_valid <= 1'b1;
        hold_empty <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
  import sst_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_sclk,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              txd,
  output logic              irq
);

  localparam int CNT_W = $clog2(DATA_W + 2);

  tx_ctl_t          tx_ctl;
  port_ctl_t        port_ctl;
  logic             data_wr;
  logic             active;
  logic             lead_evt;
  logic             trail_evt;
  logic             hold_empty;
  logic             shift_empty;
  logic             hold_valid;
  logic             load_evt;
  logic             done_evt;
  logic             wr_acc;
  logic             shift_evt;
  logic [CNT_W-1:0] bit_cnt;

  assign active = path_active(tx_ctl, port_ctl);
  assign irq    = hold_empty && port_ctl.irq_en;

  sst_regs #(.DATA_W(DATA_W)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .st_hold_empty  (hold_empty),
    .st_shift_empty (shift_empty),
    .st_irq         (irq),
    .tx_ctl         (tx_ctl),
    .port_ctl       (port_ctl),
    .data_wr        (data_wr),
    .bus_rdata      (bus_rdata)
  );

  sst_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_in (ext_sclk),
    .pol     (tx_ctl.clk_pol),
    .lead    (lead_evt),
    .trail   (trail_evt)
  );

  sst_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .data_wr     (data_wr),
    .wr_data     (bus_wdata),
    .wr_bit9     (tx_ctl.bit9),
    .nine_bit    (tx_ctl.nine_bit),
    .lead        (lead_evt),
    .trail       (trail_evt),
    .txd         (txd),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty),
    .hold_valid  (hold_valid),
    .load_evt    (load_evt),
    .done_evt    (done_evt),
    .wr_acc      (wr_acc),
    .shift_evt   (shift_evt),
    .bit_cnt     (bit_cnt)
  );

endmodule

// File: rtl/sst_chk.sv
module sst_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             load_evt,
  input logic             done_evt,
  input logic             wr_acc,
  input logic             lead_evt,
  input logic             hold_valid,
  input logic             shift_empty,
  input logic             hold_empty,
  input logic             irq,
  input logic             txd,
  input logic [CNT_W-1:0] bit_cnt
);

  assert_gated_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (shift_empty && !hold_valid));

  assert_load_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (hold_empty && !shift_empty));

  assert_pending_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !shift_empty) |=> !hold_empty);

  assert_done_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> shift_empty);

  assert_txd_on_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lead_evt |=> $stable(txd));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(DATA_W + 1));

  assert_irq_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> hold_empty);

endmodule

bind sync_slave_tx sst_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .active      (active),
  .load_evt    (load_evt),
  .done_evt    (done_evt),
  .wr_acc      (wr_acc),
  .lead_evt    (lead_evt),
  .hold_valid  (hold_valid),
  .shift_empty (shift_empty),
  .hold_empty  (hold_empty),
  .irq         (irq),
  .txd         (txd),
  .bit_cnt     (bit_cnt)
);

// File: tb/sim_sync_slave_tx.sv
module sim_sync_slave_tx;

  localparam int CLK_NS = 10;
  localparam int HALF   = 8;   // system cycles per shift clock half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_sclk = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       txd;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_NS / 2) clk = ~clk;

  sync_slave_tx u0 (
    .clk(clk), .rst_n(rst_n), .ext_sclk(ext_sclk), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .irq(irq)
  );

  typedef struct packed {
    logic [7:0] txc;
    logic [7:0] pc;
    logic [7:0] d;
    logic [3:0] nb;
    logic [8:0] exp;
    logic       sent;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h03, 8'h01, 8'hA5, 4'd8, 9'h0A5, 1'b1},
    '{8'h23, 8'h01, 8'h3C, 4'd8, 9'h03C, 1'b1},
    '{8'h1B, 8'h01, 8'h96, 4'd9, 9'h196, 1'b1},
    '{8'h2B, 8'h09, 8'hFF, 4'd9, 9'h0FF, 1'b1},
    '{8'h03, 8'h09, 8'h01, 4'd8, 9'h001, 1'b1},
    '{8'h07, 8'h01, 8'h5A, 4'd8, 9'h000, 1'b0},
    '{8'h03, 8'h03, 8'h5A, 4'd8, 9'h000, 1'b0},
    '{8'h03, 8'h05, 8'h5A, 4'd8, 9'h000, 1'b0},
    '{8'h01, 8'h01, 8'h5A, 4'd8, 9'h000, 1'b0},
    '{8'h02, 8'h01, 8'h5A, 4'd8, 9'h000, 1'b0},
    '{8'h03, 8'h00, 8'h5A, 4'd8, 9'h000, 1'b0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic pol);
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; ext_sclk = pol;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic shift_bits(input int n, input logic pol, output logic [8:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      ext_sclk = ~pol;
      repeat (HALF) @(negedge clk);
      w[i] = txd;
      ext_sclk = pol;
      repeat (HALF) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1..all actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [8:0] w;

    // table of single-word transfers: R1, R5, R6, R9
    for (int v = 0; v < NV; v++) begin
      do_reset(VECS[v].txc[5]);
      bus_write(2'd2, VECS[v].pc);
      bus_write(2'd1, VECS[v].txc);
      bus_write(2'd0, VECS[v].d);
      repeat (2) @(negedge clk);
      bus_read(2'd3, r);
      if (VECS[v].sent) begin
        chk(r, {5'd0, VECS[v].pc[3], 2'b01}, $sformatf("R2 load status vec %0d", v));
        shift_bits(VECS[v].nb, VECS[v].txc[5], w);
        chk(w, VECS[v].exp, $sformatf("R5/R6/R9 word vec %0d", v));
        bus_read(2'd3, r);
        chk(r, {5'd0, VECS[v].pc[3], 2'b11}, $sformatf("R4 end status vec %0d", v));
        chk(irq, VECS[v].pc[3], $sformatf("R7 irq pin vec %0d", v));
      end else begin
        chk(r, 8'h02, $sformatf("R1 gated status vec %0d", v));
        shift_bits(VECS[v].nb, VECS[v].txc[5], w);
        chk(w, 9'h000, $sformatf("R1 gated line vec %0d", v));
      end
    end

    // R8 reset state
    do_reset(1'b0);
    bus_read(2'd1, r); chk(r, 8'h00, "R8 tx control reset");
    bus_read(2'd2, r); chk(r, 8'h00, "R8 port control reset");
    bus_read(2'd3, r); chk(r, 8'h02, "R8 status reset");
    chk(txd, 1'b0, "R8 txd reset");
    chk(irq, 1'b0, "R8 irq reset");

    // R3, R4, R7 double buffering
    bus_write(2'd2, 8'h09);
    bus_write(2'd1, 8'h03);
    bus_write(2'd0, 8'h11);
    bus_write(2'd0, 8'h22);
    repeat (2) @(negedge clk);
    bus_read(2'd3, r); chk(r, 8'h00, "R3 pending word status");
    chk(irq, 1'b0, "R7 irq low while pending");
    shift_bits(8, 1'b0, w); chk(w, 9'h011, "R5 first queued word");
    bus_read(2'd3, r); chk(r, 8'h05, "R4 second word loaded");
    shift_bits(8, 1'b0, w); chk(w, 9'h022, "R4 second queued word");
    bus_read(2'd3, r); chk(r, 8'h07, "R4 both words done");
    bus_write(2'd2, 8'h01);
    @(negedge clk); chk(irq, 1'b0, "R7 irq masked");
    bus_write(2'd2, 8'h09);
    @(negedge clk); chk(irq, 1'b1, "R7 irq unmasked");

    // R6 ninth bit captured at write time
    do_reset(1'b0);
    bus_write(2'd2, 8'h01);
    bus_write(2'd1, 8'h1B);
    bus_write(2'd0, 8'h80);
    bus_write(2'd0, 8'h01);
    bus_write(2'd1, 8'h0B);
    shift_bits(9, 1'b0, w); chk(w, 9'h180, "R6 first nine-bit word");
    shift_bits(9, 1'b0, w); chk(w, 9'h101, "R6 ninth bit held from write");

    // R10 abort mid-word
    do_reset(1'b0);
    bus_write(2'd2, 8'h01);
    bus_write(2'd1, 8'h03);
    bus_write(2'd0, 8'hF0);
    bus_write(2'd0, 8'h0F);
    shift_bits(3, 1'b0, w);
    bus_write(2'd1, 8'h02);
    repeat (2) @(negedge clk);
    bus_read(2'd3, r); chk(r, 8'h02, "R10 abort status");
    bus_write(2'd1, 8'h03);
    shift_bits(8, 1'b0, w); chk(w, 9'h000, "R10 nothing sent after abort");
    bus_read(2'd3, r); chk(r, 8'h02, "R10 still empty");

    // R11 read map
    bus_write(2'd1, 8'h2B);
    bus_write(2'd2, 8'h09);
    bus_read(2'd1, r); chk(r, 8'h2B, "R11 tx control readback");
    bus_read(2'd2, r); chk(r, 8'h09, "R11 port control readback");
    bus_read(2'd0, r); chk(r, 8'h00, "R11 data address reads zero");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule